// File: doc/BRIEF.md
# Parallel Port Bus Interface

This block is the processor-facing side of a 24-line parallel I/O controller with three 8-bit ports (A, B and C). A processor reaches it through an 8-bit data bus, an active-low chip select, active-low read and write strobes and a 2-bit address. The address picks port A, port B, port C or a control register. Inside a chip the data bus is split into an input, an output and an output enable, and the pad ring joins them. Each port pin is split the same way.

A word written to the control register has one of two meanings, set by its top bit. A mode word (bit 7 = 1) sets the mode and the direction of each port, with a separate direction for each nibble of port C, and clears every output latch. A set/reset word (bit 7 = 0) sets or clears one bit of port C. It leaves ports A and B and the mode unchanged. In simple mode, writes go into output latches. Reads of an input port return the live pins, and reads of an output port return the latch. The mode fields are brought out for handshake logic that lives outside this block.

The strobes are sampled on `clk` by a four-state machine:
- `ST_IDLE` goes to `ST_WRITE` when select and write are low. A write wins if read is also low.
- `ST_IDLE` goes to `ST_READ` when select and read are low and write is high.
- `ST_WRITE` is the single commit cycle. It goes to `ST_HOLD` while the write stays low, otherwise back to `ST_IDLE`.
- `ST_HOLD` waits for the write or the select to rise, then returns to `ST_IDLE`.
- `ST_READ` drives the bus. It returns to `ST_IDLE` as soon as select or read rises, or write falls.

Top module: `ppi_bus_if`

## Requirements
- R1: After reset the control register reads 0x9B, which makes all ports mode-0 inputs. All output enables are 0 and all output latches are 0.
- R2: The address selects the target: 0 = port A, 1 = port B, 2 = port C, 3 = control register.
- R3: While `cs_n` is high, no write changes any state and `data_oe` stays 0.
- R4: `data_oe` is 1 only in a cycle that follows an edge where `cs_n` and `rd_n` were both low with `wr_n` high. It drops one edge after any of these conditions ends.
- R5: A write commits exactly once for each period in which the strobe is low. The commit uses `addr` and `data_i` sampled at the second rising edge after `cs_n` and `wr_n` are seen low.
- R6: In a mode word, bits 6:5 are the group A mode, bit 4 the port A direction, bit 3 the port C upper-nibble direction, bit 2 the group B mode, bit 1 the port B direction and bit 0 the port C lower-nibble direction. A direction bit of 1 means input, and an input drives its output enable to 0.
- R7: Writing a mode word clears the port A, B and C output latches.
- R8: In a set/reset word (bit 7 = 0), bits 3:1 give the port C bit index and bit 0 the new value. Ports A and B and the mode are unchanged.
- R9: Reading port A or B returns the live pins if that port is an input, else its latch. Port C makes this choice per nibble.
- R10: Reading the control register returns the last mode word written.
- R11: `grp_a_mode` and `grp_b_mode` show the mode fields of the current mode word.
- R12: If read and write are both low in `ST_IDLE`, the write is taken and the bus is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Target select |
| data_i | input | 8 | Write data from processor |
| data_o | output | 8 | Read data to processor |
| data_oe | output | 1 | Data bus drive enable |
| pa_i | input | 8 | Port A pins in |
| pa_o | output | 8 | Port A latch out |
| pa_oe | output | 1 | Port A drive enable |
| pb_i | input | 8 | Port B pins in |
| pb_o | output | 8 | Port B latch out |
| pb_oe | output | 1 | Port B drive enable |
| pc_i | input | 8 | Port C pins in |
| pc_o | output | 8 | Port C latch out |
| pc_oe | output | 8 | Port C per-bit drive enable |
| grp_a_mode | output | 2 | Group A mode field |
| grp_b_mode | output | 1 | Group B mode field |

## Verification
Directed sequences come first:
- The reset readback.
- Every set/reset index, with both set and clear.
- A mode word written after latches were loaded.
- Writes with select high.
- Read and write strobes low together.

These separate the two meanings of a control word and show that deselected and colliding accesses have no effect. A seeded random mix of mode words, set/reset words, port writes, pin values and deselected accesses then follows. Every read is compared against a bench model. This exercises each mix of nibble and port directions, so a wrong choice between live pins and the latch shows up on the bus.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
    localparam int PORT_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_HOLD  = 2'd2,
        ST_READ  = 2'd3
    } bus_state_t;

    typedef enum logic [1:0] {
        SEL_PA   = 2'd0,
        SEL_PB   = 2'd1,
        SEL_PC   = 2'd2,
        SEL_CTRL = 2'd3
    } sel_t;

    typedef struct packed {
        logic       is_mode;
        logic [1:0] a_mode;
        logic       a_in;
        logic       ch_in;
        logic       b_mode;
        logic       b_in;
        logic       cl_in;
    } mode_word_t;

    localparam logic [7:0] RESET_MODE = 8'h9B;
endpackage

// File: rtl/ppi_bus_fsm.sv
module ppi_bus_fsm
    import ppi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic rd_n,
    input  logic wr_n,
    output logic wr_pulse,
    output logic rd_active
);
    bus_state_t state, nxt;
    logic sel_wr, sel_rd;

    assign sel_wr = !cs_n && !wr_n;
    assign sel_rd = !cs_n && !rd_n && wr_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (sel_wr) nxt = ST_WRITE;
                      else if (sel_rd) nxt = ST_READ;
            ST_WRITE: nxt = sel_wr ? ST_HOLD : ST_IDLE;
            ST_HOLD:  nxt = sel_wr ? ST_HOLD : ST_IDLE;
            ST_READ:  nxt = sel_rd ? ST_READ : ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        wr_pulse  = (state == ST_WRITE);
        rd_active = (state == ST_READ);
    end

    // R5
    one_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);

    // R4
    drive_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_active |-> $past(!cs_n && !rd_n && wr_n));
endmodule

// File: rtl/ppi_regs.sv
module ppi_regs
    import ppi_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_pulse,
    input  logic [1:0]   addr,
    input  logic [W-1:0] wdata,
    output mode_word_t   mode_q,
    output logic [W-1:0] pa_q,
    output logic [W-1:0] pb_q,
    output logic [W-1:0] pc_q
);
    localparam int IDXW = $clog2(W);

    logic [IDXW-1:0] bit_idx;
    assign bit_idx = wdata[IDXW:1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= mode_word_t'(RESET_MODE);
            pa_q   <= '0;
            pb_q   <= '0;
            pc_q   <= '0;
        end else if (wr_pulse) begin
            unique case (sel_t'(addr))
                SEL_PA: pa_q <= wdata;
                SEL_PB: pb_q <= wdata;
                SEL_PC: pc_q <= wdata;
                SEL_CTRL: begin
                    if (wdata[7]) begin
                        mode_q <= mode_word_t'(wdata[7:0]);
                        pa_q   <= '0;
                        pb_q   <= '0;
                        pc_q   <= '0;
                    end else begin
                        pc_q[bit_idx] <= wdata[0];
                    end
                end
                default: ;
            endcase
        end
    end

    // R8
    bsr_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && addr == 2'd3 && !wdata[7]) |=>
        ($stable(pa_q) && $stable(pb_q) && $stable(mode_q)
         && $countones(pc_q ^ $past(pc_q)) <= 1));

    // R7
    mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && addr == 2'd3 && wdata[7]) |=>
        (pa_q == '0 && pb_q == '0 && pc_q == '0));

    // R2
    pa_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && addr == 2'd0) |=>
        (pa_q == $past(wdata) && $stable(pb_q) && $stable(pc_q)));
endmodule

// File: rtl/ppi_read_mux.sv
module ppi_read_mux
    import ppi_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic [1:0]   addr,
    input  mode_word_t   mode_q,
    input  logic [W-1:0] pa_q,
    input  logic [W-1:0] pb_q,
    input  logic [W-1:0] pc_q,
    input  logic [W-1:0] pa_i,
    input  logic [W-1:0] pb_i,
    input  logic [W-1:0] pc_i,
    output logic [W-1:0] rdata
);
    localparam int HALF = W / 2;

    logic [W-1:0] pc_view;

    assign pc_view[W-1:HALF] = mode_q.ch_in ? pc_i[W-1:HALF] : pc_q[W-1:HALF];
    assign pc_view[HALF-1:0] = mode_q.cl_in ? pc_i[HALF-1:0] : pc_q[HALF-1:0];

    always_comb begin
        unique case (sel_t'(addr))
            SEL_PA:   rdata = mode_q.a_in ? pa_i : pa_q;
            SEL_PB:   rdata = mode_q.b_in ? pb_i : pb_q;
            SEL_PC:   rdata = pc_view;
            SEL_CTRL: rdata = W'(mode_q);
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/ppi_bus_if.sv
module ppi_bus_if
    import ppi_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n,
    input  logic         rd_n,
    input  logic         wr_n,
    input  logic [1:0]   addr,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] data_o,
    output logic         data_oe,
    input  logic [W-1:0] pa_i,
    output logic [W-1:0] pa_o,
    output logic         pa_oe,
    input  logic [W-1:0] pb_i,
    output logic [W-1:0] pb_o,
    output logic         pb_oe,
    input  logic [W-1:0] pc_i,
    output logic [W-1:0] pc_o,
    output logic [W-1:0] pc_oe,
    output logic [1:0]   grp_a_mode,
    output logic         grp_b_mode
);
    localparam int HALF = W / 2;

    logic         wr_pulse, rd_active;
    mode_word_t   mode_q;
    logic [W-1:0] pa_q, pb_q, pc_q, rdata;

    ppi_bus_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .wr_pulse(wr_pulse), .rd_active(rd_active)
    );

    ppi_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_pulse(wr_pulse), .addr(addr),
        .wdata(data_i), .mode_q(mode_q), .pa_q(pa_q), .pb_q(pb_q), .pc_q(pc_q)
    );

    ppi_read_mux #(.W(W)) u_mux (
        .addr(addr), .mode_q(mode_q), .pa_q(pa_q), .pb_q(pb_q), .pc_q(pc_q),
        .pa_i(pa_i), .pb_i(pb_i), .pc_i(pc_i), .rdata(rdata)
    );

    assign data_oe    = rd_active;
    assign data_o     = rd_active ? rdata : '0;
    assign pa_o       = pa_q;
    assign pb_o       = pb_q;
    assign pc_o       = pc_q;
    assign pa_oe      = !mode_q.a_in;
    assign pb_oe      = !mode_q.b_in;
    assign pc_oe      = {{(W-HALF){!mode_q.ch_in}}, {HALF{!mode_q.cl_in}}};
    assign grp_a_mode = mode_q.a_mode;
    assign grp_b_mode = mode_q.b_mode;

    // R3
    desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && !rd_active) |=> !data_oe);
endmodule

// File: tb/test_ppi_bus_if.sv
module test_ppi_bus_if;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = 2'd0;
    logic [7:0] data_i = 8'h00;
    logic [7:0] pa_i = 8'h00, pb_i = 8'h00, pc_i = 8'h00;
    logic [7:0] data_o, pa_o, pb_o, pc_o, pc_oe;
    logic       data_oe, pa_oe, pb_oe, grp_b_mode;
    logic [1:0] grp_a_mode;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0] m_mode, m_pa, m_pb, m_pc;

    always #2 clk = ~clk;

    ppi_bus_if i_ppi_bus_if (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .data_i(data_i), .data_o(data_o), .data_oe(data_oe),
        .pa_i(pa_i), .pa_o(pa_o), .pa_oe(pa_oe),
        .pb_i(pb_i), .pb_o(pb_o), .pb_oe(pb_oe),
        .pc_i(pc_i), .pc_o(pc_o), .pc_oe(pc_oe),
        .grp_a_mode(grp_a_mode), .grp_b_mode(grp_b_mode)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0: return m_mode[4] ? pa_i : m_pa;
            2'd1: return m_mode[1] ? pb_i : m_pb;
            2'd2: return {m_mode[3] ? pc_i[7:4] : m_pc[7:4],
                          m_mode[0] ? pc_i[3:0] : m_pc[3:0]};
            default: return m_mode;
        endcase
    endfunction

    function automatic void model_write(input logic [1:0] a, input logic [7:0] d);
        case (a)
            2'd0: m_pa = d;
            2'd1: m_pb = d;
            2'd2: m_pc = d;
            default: if (d[7]) begin
                m_mode = d; m_pa = 0; m_pb = 0; m_pc = 0;
            end else m_pc[d[3:1]] = d[0];
        endcase
    endfunction

    task automatic check_pins(input string req);
        check(req, {pa_o, pb_o, pc_o}, {m_pa, m_pb, m_pc});
        check(req, {pa_oe, pb_oe, pc_oe},
              {!m_mode[4], !m_mode[1], {4{!m_mode[3]}}, {4{!m_mode[0]}}});
        check(req, {grp_a_mode, grp_b_mode}, {m_mode[6:5], m_mode[2]});
    endtask

    task automatic do_write(input logic [1:0] a, input logic [7:0] d, input logic sel);
        @(negedge clk);
        cs_n = !sel; wr_n = 1'b0; addr = a; data_i = d;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        check("R12", data_oe, 1'b0);
        cs_n = 1'b1; wr_n = 1'b1;
        @(posedge clk); @(negedge clk);
        if (sel) model_write(a, d);
    endtask

    task automatic do_read(input logic [1:0] a, input string req);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        @(posedge clk); @(negedge clk);
        check("R4", data_oe, 1'b1);
        check(req, data_o, exp_read(a));
        cs_n = 1'b1; rd_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R4", data_oe, 1'b0);
    endtask

    initial begin
        #400000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        m_mode = 8'h9B; m_pa = 0; m_pb = 0; m_pc = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", data_oe, 1'b0);
        check_pins("R1");
        do_read(2'd3, "R1");

        // R6 / R11: all outputs, mode fields nonzero
        do_write(2'd3, 8'hC4, 1'b1);
        check_pins("R6");
        check("R11", {grp_a_mode, grp_b_mode}, 3'b101);
        // R2 decode, R9 output readback
        do_write(2'd0, 8'h3C, 1'b1);
        do_write(2'd1, 8'hA5, 1'b1);
        do_write(2'd2, 8'h81, 1'b1);
        check_pins("R2");
        do_read(2'd0, "R2"); do_read(2'd1, "R2"); do_read(2'd2, "R2");
        // R10 readback of mode word after other writes
        do_read(2'd3, "R10");

        // R8 each index, set then clear
        for (int i = 0; i < 8; i++) begin
            do_write(2'd3, {4'b0000, 3'(i), 1'b1}, 1'b1);
            check_pins("R8");
        end
        for (int i = 0; i < 8; i++) begin
            do_write(2'd3, {4'b0111, 3'(i), 1'b0}, 1'b1);
            check_pins("R8");
        end
        do_read(2'd3, "R8");

        // R7 mode word clears latches
        do_write(2'd0, 8'hFF, 1'b1);
        do_write(2'd2, 8'h5A, 1'b1);
        do_write(2'd3, 8'h80, 1'b1);
        check("R7", {pa_o, pb_o, pc_o}, 24'h0);

        // R3 deselected write and read
        do_write(2'd0, 8'h77, 1'b0);
        do_write(2'd3, 8'h9B, 1'b0);
        check_pins("R3");
        @(negedge clk); rd_n = 1'b0; addr = 2'd3;
        @(posedge clk); @(negedge clk);
        check("R3", data_oe, 1'b0);
        rd_n = 1'b1;

        // R12 both strobes low: write taken
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0; addr = 2'd1; data_i = 8'h6E;
        @(posedge clk); @(negedge clk);
        check("R12", data_oe, 1'b0);
        @(posedge clk); @(negedge clk);
        check("R12", data_oe, 1'b0);
        cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        @(posedge clk); @(negedge clk);
        model_write(2'd1, 8'h6E);
        check_pins("R12");

        // R5 long strobe commits once: change data during hold
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; addr = 2'd0; data_i = 8'h12;
        @(posedge clk); @(posedge clk);
        @(negedge clk); data_i = 8'hEE; addr = 2'd1;
        repeat (4) @(posedge clk);
        @(negedge clk); cs_n = 1'b1; wr_n = 1'b1;
        @(posedge clk); @(negedge clk);
        model_write(2'd0, 8'h12);
        check_pins("R5");

        // R9 random input/output mixes
        for (int k = 0; k < 400; k++) begin
            logic [1:0] a;
            logic [7:0] d;
            a = 2'($urandom);
            d = 8'($urandom);
            pa_i = 8'($urandom); pb_i = 8'($urandom); pc_i = 8'($urandom);
            case ($urandom % 4)
                0: do_write(2'd3, {1'b1, d[6:0]}, 1'b1);
                1: do_write(a, d, ($urandom % 5) != 0);
                2: do_write(2'd3, {1'b0, d[6:0]}, 1'b1);
                default: do_read(a, "R9");
            endcase
            check_pins("R6");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule